// File: doc/BRIEF.md
# Three-Phase Output Pattern Sequencer

This block drives the six raw switch levels of a three-phase inverter bridge. Each phase has a pair of outputs, the high leg and the complementary leg, so there are six in all. Software writes two six-bit patterns into buffer registers, a primary pattern and a follow-up pattern. Nothing reaches the outputs until a transfer strobe arrives. The strobe copies both buffers into an internal output stage. The primary pattern then drives all six levels at once. The follow-up pattern is parked in a hold stage inside the output stage.

Each phase also has a one-shot pulse input. When the pulse for a phase falls, that phase's two outputs take their values from the parked follow-up pattern. A read of the pattern port returns what the output stage is driving, not what software last wrote. The six outputs feed a separate dead-time stage. The timers and dead-time insertion sit outside this block.

Top module: `phase_pattern_seq`

## Requirements
- R1: After reset, `phase_lvl` is 6'h3F, so every leg is inactive, and `rd_data` reads 8'h3F.
- R2: A write without a transfer strobe leaves `phase_lvl` unchanged. Pattern bit b0 is U, b1 is U-bar, b2 is V, b3 is V-bar, b4 is W and b5 is W-bar. A bit value of 0 means active and 1 means inactive.
- R3: When `xfer_trig` is high at a rising clock edge, `phase_lvl` equals the primary buffer from that edge on. `wr_sel`=0 selects the primary buffer.
- R4: A falling edge of `os_pulse[p]` loads bits 2p and 2p+1 of the held follow-up pattern into `phase_lvl` on the clock edge where the input is first sampled low. Here p=0 is U, p=1 is V and p=2 is W. The other phases keep their levels. `wr_sel`=1 selects the follow-up buffer.
- R5: A rising edge of `os_pulse`, or a steady level on it, leaves `phase_lvl` unchanged.
- R6: A write to the follow-up buffer after a strobe does not affect later falling edges until the next strobe.
- R7: A write and a transfer strobe in the same cycle transfer the newly written value.
- R8: When a strobe and a falling edge fall in the same cycle, the strobe wins, and `phase_lvl` takes the primary pattern.
- R9: `rd_data[5:0]` always shows the current output-stage levels.
- R10: Write-data bits 7:6 are discarded, and `rd_data[7:6]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pattern write strobe |
| wr_sel | input | 1 | 0 selects the primary buffer, 1 selects the follow-up buffer |
| wr_data | input | 8 | Write data; bits 5:0 hold the pattern |
| rd_data | output | 8 | Read data: the output-stage levels, with the upper bits 0 |
| xfer_trig | input | 1 | Transfer strobe |
| os_pulse | input | 3 | One-shot pulse inputs, one each for U, V and W |
| phase_lvl | output | 6 | Raw leg levels sent to the dead-time stage |

## Verification
Two pairs of events can coincide in one cycle.

The first pair is a primary-buffer write and a transfer strobe. The bench raises both in the same cycle. It judges the result by whether the new data, rather than the stale buffer, appears on `phase_lvl` one edge later.

The second pair is a transfer strobe and a one-shot falling edge. The bench drops a pulse in the same cycle as the strobe. It expects the primary pattern to remain on the outputs, and it expects the edge to leave no trace.

// File: rtl/pps_pkg.sv
package pps_pkg;
   // Roles of the two pattern buffers, as selected by wr_sel
   typedef enum logic {
      BUF_PRIMARY  = 1'b0,
      BUF_FOLLOWUP = 1'b1
   } buf_sel_e;

   localparam int unsigned DEF_N_PHASE = 3;
   localparam int unsigned DEF_LEGS    = 2;
   localparam int unsigned DEF_DATA_W  = 8;
endpackage

// File: rtl/pps_pattern_regs.sv
module pps_pattern_regs
   import pps_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned PAT_W  = DEF_N_PHASE * DEF_LEGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PAT_W-1:0]  first_q,
   output logic [PAT_W-1:0]  second_q,
   output logic [PAT_W-1:0]  first_nx,
   output logic [PAT_W-1:0]  second_nx
);
   logic wr_first, wr_second;

   assign wr_first  = wr_en && (buf_sel_e'(wr_sel) == BUF_PRIMARY);
   assign wr_second = wr_en && (buf_sel_e'(wr_sel) == BUF_FOLLOWUP);

   // Write-first view, so a same-cycle transfer sees the new data
   assign first_nx  = wr_first  ? wr_data[PAT_W-1:0] : first_q;
   assign second_nx = wr_second ? wr_data[PAT_W-1:0] : second_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q  <= '1;
         second_q <= '1;
      end else begin
         first_q  <= first_nx;
         second_q <= second_nx;
      end
   end
endmodule

// File: rtl/pps_edge_det.sv
module pps_edge_det #(
   parameter int unsigned N     = 3,
   parameter bit          FALL  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] evt
);
   logic [N-1:0] sig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sig_q <= '0;
      else        sig_q <= sig;
   end

   for (genvar i = 0; i < N; i++) begin : g_ch
      if (FALL) begin : g_fall
         assign evt[i] = sig_q[i] & ~sig[i];
      end else begin : g_rise
         assign evt[i] = ~sig_q[i] & sig[i];
      end
   end
endmodule

// File: rtl/pps_out_stage.sv
module pps_out_stage #(
   parameter int unsigned N_PHASE = 3,
   parameter int unsigned LEGS    = 2,
   localparam int unsigned PAT_W  = N_PHASE * LEGS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [PAT_W-1:0]   first_nx,
   input  logic [PAT_W-1:0]   second_nx,
   input  logic [N_PHASE-1:0] evt,
   output logic [PAT_W-1:0]   lvl,
   output logic [PAT_W-1:0]   hold
);
   always_ff @(posedge clk) begin
      if (!rst_n)    hold <= '1;
      else if (load) hold <= second_nx;
   end

   for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
      logic [LEGS-1:0] leg_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      leg_q <= '1;
         else if (load)   leg_q <= first_nx[p*LEGS +: LEGS];
         else if (evt[p]) leg_q <= hold[p*LEGS +: LEGS];
      end
      assign lvl[p*LEGS +: LEGS] = leg_q;
   end
endmodule

// File: rtl/phase_pattern_seq.sv
module phase_pattern_seq
   import pps_pkg::*;
#(
   parameter int unsigned N_PHASE = DEF_N_PHASE,
   parameter int unsigned LEGS    = DEF_LEGS,
   parameter int unsigned DATA_W  = DEF_DATA_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       wr_sel,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   input  logic                       xfer_trig,
   input  logic [N_PHASE-1:0]         os_pulse,
   output logic [N_PHASE*LEGS-1:0]    phase_lvl
);
   localparam int unsigned PAT_W = N_PHASE * LEGS;

   if (DATA_W <= PAT_W) begin : g_bad_width
      $error("DATA_W must exceed the pattern width");
   end
   if (N_PHASE < 1 || LEGS < 1) begin : g_bad_shape
      $error("N_PHASE and LEGS must be at least 1");
   end

   logic [PAT_W-1:0]   first_q, second_q, first_nx, second_nx, hold_q;
   logic [N_PHASE-1:0] fall_evt;

   pps_pattern_regs #(.DATA_W(DATA_W), .PAT_W(PAT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .first_q   (first_q),
      .second_q  (second_q),
      .first_nx  (first_nx),
      .second_nx (second_nx)
   );

   pps_edge_det #(.N(N_PHASE), .FALL(1'b1)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   (os_pulse),
      .evt   (fall_evt)
   );

   pps_out_stage #(.N_PHASE(N_PHASE), .LEGS(LEGS)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (xfer_trig),
      .first_nx  (first_nx),
      .second_nx (second_nx),
      .evt       (fall_evt),
      .lvl       (phase_lvl),
      .hold      (hold_q)
   );

   assign rd_data = {{(DATA_W-PAT_W){1'b0}}, phase_lvl};
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
   parameter int unsigned N_PHASE = 3,
   parameter int unsigned LEGS    = 2,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned PAT_W  = N_PHASE * LEGS
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               wr_sel,
   input logic [DATA_W-1:0]  wr_data,
   input logic               xfer_trig,
   input logic [N_PHASE-1:0] os_pulse,
   input logic [PAT_W-1:0]   phase_lvl,
   input logic [PAT_W-1:0]   first_q,
   input logic [PAT_W-1:0]   hold_q
);
   logic [N_PHASE-1:0] os_seen;
   logic [N_PHASE-1:0] fall;

   always_ff @(posedge clk) begin
      if (!rst_n) os_seen <= '0;
      else        os_seen <= os_pulse;
   end
   assign fall = os_seen & ~os_pulse;

   // R3 and R8: a strobe loads the primary buffer, even when an edge falls in the same cycle
   p_trig_loads_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_trig && !(wr_en && !wr_sel)) |=> phase_lvl == $past(first_q));

   p_write_trig_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_trig && wr_en && !wr_sel) |=> phase_lvl == $past(wr_data[PAT_W-1:0]));

   // R2 and R5: with no strobe and no falling edge, the outputs hold
   p_quiet_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_trig && fall == '0) |=> $stable(phase_lvl));

   for (genvar p = 0; p < N_PHASE; p++) begin : g_ph
      p_fall_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!xfer_trig && fall[p]) |=> phase_lvl[p*LEGS +: LEGS] == $past(hold_q[p*LEGS +: LEGS]));
   end
endmodule

bind phase_pattern_seq pps_checker #(.N_PHASE(N_PHASE), .LEGS(LEGS), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .xfer_trig (xfer_trig),
   .os_pulse  (os_pulse),
   .phase_lvl (phase_lvl),
   .first_q   (first_q),
   .hold_q    (hold_q)
);

// File: tb/test_phase_pattern_seq.sv
module test_phase_pattern_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       xfer_trig = 1'b0;
   logic [2:0] os_pulse = 3'b000;
   logic [5:0] phase_lvl;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   phase_pattern_seq i_phase_pattern_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .xfer_trig (xfer_trig),
      .os_pulse  (os_pulse),
      .phase_lvl (phase_lvl)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_trig();
      @(negedge clk);
      xfer_trig = 1'b1;
      @(negedge clk);
      xfer_trig = 1'b0;
   endtask

   task automatic pulse_rise(input int p);
      @(negedge clk);
      os_pulse[p] = 1'b1;
      @(negedge clk);
   endtask

   task automatic pulse_fall(input int p);
      os_pulse[p] = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 phase_lvl", {2'b00, phase_lvl}, 8'h3F);
      check("R1 rd_data", rd_data, 8'h3F);
   endtask

   task automatic t_write_no_effect();
      do_write(1'b0, 8'h00);
      do_write(1'b1, 8'h2A);
      check("R2 no strobe", {2'b00, phase_lvl}, 8'h3F);
      check("R9 read shows stage", rd_data, 8'h3F);
   endtask

   task automatic t_trigger();
      do_trig();
      check("R3 primary loaded", {2'b00, phase_lvl}, 8'h00);
      check("R9 read after load", rd_data, 8'h00);
   endtask

   task automatic t_fall_each();
      pulse_rise(0);
      check("R5 rising edge", {2'b00, phase_lvl}, 8'h00);
      pulse_fall(0);
      check("R4 U fall", {2'b00, phase_lvl}, 8'h02);
      pulse_rise(1);
      pulse_fall(1);
      check("R4 V fall", {2'b00, phase_lvl}, 8'h0A);
      pulse_rise(2);
      check("R5 high level", {2'b00, phase_lvl}, 8'h0A);
      pulse_fall(2);
      check("R4 W fall", {2'b00, phase_lvl}, 8'h2A);
   endtask

   task automatic t_latched();
      do_write(1'b1, 8'h15);
      pulse_rise(2);
      pulse_fall(2);
      check("R6 held follow-up", {2'b00, phase_lvl}, 8'h2A);
   endtask

   task automatic t_write_and_trig();
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hFC; xfer_trig = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; xfer_trig = 1'b0;
      check("R7 same-cycle write", {2'b00, phase_lvl}, 8'h3C);
      check("R10 upper bits", rd_data, 8'h3C);
   endtask

   task automatic t_trig_and_fall();
      pulse_rise(1);
      os_pulse[1] = 1'b0; xfer_trig = 1'b1;
      @(negedge clk);
      xfer_trig = 1'b0;
      check("R8 strobe wins", {2'b00, phase_lvl}, 8'h3C);
      @(negedge clk);
      check("R8 edge consumed", {2'b00, phase_lvl}, 8'h3C);
      pulse_rise(1);
      pulse_fall(1);
      check("R4 V from new hold", {2'b00, phase_lvl}, 8'h34);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_no_effect();
      t_trigger();
      t_fall_each();
      t_latched();
      t_write_and_trig();
      t_trig_and_fall();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule